// File: doc/BRIEF.md
# USB Control Endpoint Register Interface

This block is the register side of a low-speed USB device's default control endpoint. The microcontroller sees five byte registers: the device address, a control/status register for endpoint 0, a status register for the interrupt endpoint, a received-byte count, and a single data-window address through which an eight-byte FIFO is loaded or drained. A packet engine (serial engine, bit coding, CRC and transceiver live elsewhere) moves packet bytes in and out over two byte streams and reports packet events with one-cycle strobes.

The FIFO works in one direction at a time. It starts out holding host-to-device data. Once the microcontroller releases a received setup packet, the FIFO turns to whatever direction bit 7 of the first setup byte asked for. Status flags are never cleared by writing zero over them. They are cleared either by dedicated write-one command bits that read back as zero, or by the packet engine.

Register select (`reg_addr`): 0 = device address, 1 = endpoint 0 control/status, 2 = interrupt endpoint status, 3 = byte count, 4 = FIFO window. Other selects read 00h. The stream interfaces use valid/ready. A byte moves on a rising edge where both are high. A source holds its data stable while valid is high and ready is low. Ready may drop at any time without the transfer being lost.

Top module: `usb_ep0_regs`

## Requirements
- R1: Writing register 0 stores bits 6..0 as the device address on `func_addr`. Register 0 reads back the address with bit 7 always 0.
- R2: After reset every register reads 00h, the FIFO is empty and faces host-to-device (`ep0_dir_in`=0), `rx_ready`=1 and `tx_valid`=0.
- R3: While the FIFO faces host-to-device, the ready flag (status bit 0) is clear and the FIFO is not full, `rx_ready` is high. When the FIFO holds 8 bytes, `rx_ready` goes low. A `pe_rx_done` strobe sets status bit 0, and `rx_ready` then stays low.
- R4: Reads of register 4 return the received bytes in arrival order. A read of an empty FIFO, or any read while the FIFO faces device-to-host, returns 00h and removes nothing.
- R5: Writing 1 to status bit 6 clears bit 0 and empties the FIFO. Bit 6 reads as 0. If the packet just released was a setup packet, `ep0_dir_in` takes bit 7 of its first byte. A `pe_setup` strobe always returns the direction to host-to-device.
- R6: A `pe_setup` strobe that arrives while a control transfer is still open sets status bit 4. Writing 1 to bit 7 clears bit 4, and bit 7 reads as 0.
- R7: While the FIFO faces device-to-host and status bit 1 is clear, writes to register 4 fill the FIFO, and writes beyond 8 bytes are dropped. Writing 1 to bit 1 offers the bytes in order on the `tx` stream. `pe_tx_done` clears bit 1 and empties the FIFO.
- R8: Writing 1 to status bit 3 sets it. The next `pe_rx_done`, `pe_tx_done` or `pe_setup` clears it. A packet completion that finds bit 3 set closes the control transfer, so the next setup does not set bit 4.
- R9: Status bit 5 is read/write and drives `stall_req`. `pe_stall_sent` sets bit 2. Any status write with bit 5 = 0 clears bit 2.
- R10: `pe_bus_reset` clears the device address, the byte count, all status bits and the interrupt endpoint toggle. It also empties the FIFO and turns it to host-to-device.
- R11: Register 2 reads the interrupt endpoint toggle in bit 0. Each `ep1_ack` strobe flips the toggle. Writing 1 to bit 7 resets it to DATA0 (0), and bit 7 reads as 0.
- R12: Register 3 is loaded with the FIFO occupancy only on `pe_rx_done`. Reads of the FIFO do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO on select 4) |
| reg_addr | input | 3 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the current select, combinational |
| func_addr | output | 7 | Device address |
| rx_valid | input | 1 | Received byte valid |
| rx_ready | output | 1 | FIFO can take a received byte |
| rx_data | input | 8 | Received byte |
| tx_valid | output | 1 | Byte offered to the packet engine |
| tx_ready | input | 1 | Packet engine takes the byte |
| tx_data | output | 8 | Byte to transmit |
| pe_setup | input | 1 | Setup token seen; the next packet is setup data |
| pe_rx_done | input | 1 | Data packet fully received |
| pe_tx_done | input | 1 | IN packet sent and acknowledged |
| pe_stall_sent | input | 1 | A STALL handshake was sent |
| pe_bus_reset | input | 1 | USB bus reset detected |
| ep1_ack | input | 1 | Interrupt endpoint transaction acknowledged |
| stall_req | output | 1 | Request to stall endpoint 0 |
| ep0_dir_in | output | 1 | FIFO direction, 1 = device-to-host |
| ep1_toggle | output | 1 | Interrupt endpoint data toggle |

## Verification
A wrong direction flag shows up on the first byte after a setup packet is released: `rx_ready` or `tx_valid` takes the wrong level in the very next cycle, and FIFO reads return 00h instead of data. A pointer or occupancy error shows up as out-of-order or missing bytes on the next read or transmit burst, and in a wrong value loaded into the byte count at the following `pe_rx_done`. A status flag that fails to set or clear is visible on register 1 one cycle after the command or strobe.

// File: rtl/usb_ep0_pkg.sv
package usb_ep0_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_FADDR = 3'd0,
    SEL_EP0   = 3'd1,
    SEL_EP1   = 3'd2,
    SEL_BCNT  = 3'd3,
    SEL_FIFO  = 3'd4
  } reg_sel_e;

  // endpoint 0 control/status bit positions
  localparam int B_CLR_SETUP_END = 7;
  localparam int B_CLR_OUT       = 6;
  localparam int B_SEND_STALL    = 5;
  localparam int B_SETUP_END     = 4;
  localparam int B_DATA_END      = 3;
  localparam int B_SENT_STALL    = 2;
  localparam int B_IN_RDY        = 1;
  localparam int B_OUT_RDY       = 0;
  // interrupt endpoint register
  localparam int B_EP1_CLR_TOG   = 7;
endpackage

// File: rtl/ep0_fifo.sv
module ep0_fifo #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          push_ok, pop_ok;

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign push_ok = push && !full && !flush;
  assign pop_ok  = pop && !empty && !flush;
  assign count   = cnt;
  assign rdata   = empty ? '0 : mem[rptr];

  function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
    if (p == PW'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push_ok) wptr <= ptr_next(wptr);
      if (pop_ok)  rptr <= ptr_next(rptr);
      case ({push_ok, pop_ok})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> (cnt == $past(cnt)));
  assert_empty_pop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push && !flush) |=> (cnt == '0));
endmodule

// File: rtl/ep0_csr.sv
module ep0_csr
  import usb_ep0_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              csr_wr,
  input  logic              cmd_clr_setup_end,
  input  logic              cmd_clr_out,
  input  logic              cmd_set_data_end,
  input  logic              cmd_set_in,
  input  logic              wr_stall_val,
  input  logic              pe_setup,
  input  logic              pe_rx_done,
  input  logic              pe_tx_done,
  input  logic              pe_stall_sent,
  input  logic              rx_push,
  input  logic              rx_bit7,
  output logic [DATA_W-1:0] csr_q,
  output logic              out_rdy,
  output logic              in_rdy,
  output logic              send_stall,
  output logic              dir_in,
  output logic              fifo_flush
);
  logic sent_stall, setup_end, data_end;
  logic xfer_open, setup_pending, await_first, setup_dir;
  logic pkt_done;

  assign pkt_done   = pe_rx_done || pe_tx_done;
  assign fifo_flush = pe_setup || pe_tx_done || cmd_clr_out;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_rdy <= 1'b0;  in_rdy <= 1'b0;  send_stall <= 1'b0;
      sent_stall <= 1'b0;  setup_end <= 1'b0;  data_end <= 1'b0;
      xfer_open <= 1'b0;  setup_pending <= 1'b0;  await_first <= 1'b0;
      setup_dir <= 1'b0;  dir_in <= 1'b0;
    end else if (bus_reset) begin
      out_rdy <= 1'b0;  in_rdy <= 1'b0;  send_stall <= 1'b0;
      sent_stall <= 1'b0;  setup_end <= 1'b0;  data_end <= 1'b0;
      xfer_open <= 1'b0;  setup_pending <= 1'b0;  await_first <= 1'b0;
      setup_dir <= 1'b0;  dir_in <= 1'b0;
    end else begin
      // received-packet flag
      if (pe_setup)         out_rdy <= 1'b0;
      else if (pe_rx_done)  out_rdy <= 1'b1;
      else if (cmd_clr_out) out_rdy <= 1'b0;

      // transmit-packet flag
      if (pe_setup || pe_tx_done) in_rdy <= 1'b0;
      else if (cmd_set_in)        in_rdy <= 1'b1;

      // last-stage marker
      if (pe_setup || pkt_done)   data_end <= 1'b0;
      else if (cmd_set_data_end)  data_end <= 1'b1;

      // control transfer bracket
      if (pe_setup)                    xfer_open <= 1'b1;
      else if (pkt_done && data_end)   xfer_open <= 1'b0;

      if (pe_setup && xfer_open)       setup_end <= 1'b1;
      else if (cmd_clr_setup_end)      setup_end <= 1'b0;

      // stall handshake
      if (csr_wr) send_stall <= wr_stall_val;
      if (pe_stall_sent)                 sent_stall <= 1'b1;
      else if (csr_wr && !wr_stall_val)  sent_stall <= 1'b0;

      // FIFO direction
      if (pe_setup) begin
        dir_in        <= 1'b0;
        setup_pending <= 1'b1;
        await_first   <= 1'b1;
      end else begin
        if (rx_push && await_first) begin
          setup_dir   <= rx_bit7;
          await_first <= 1'b0;
        end
        if (cmd_clr_out && setup_pending && !pe_rx_done) begin
          dir_in        <= setup_dir;
          setup_pending <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    csr_q                  = '0;
    csr_q[B_SEND_STALL]    = send_stall;
    csr_q[B_SETUP_END]     = setup_end;
    csr_q[B_DATA_END]      = data_end;
    csr_q[B_SENT_STALL]    = sent_stall;
    csr_q[B_IN_RDY]        = in_rdy;
    csr_q[B_OUT_RDY]       = out_rdy;
  end

  assert_clr_setup_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_clr_setup_end && !pe_setup) |=> !csr_q[B_SETUP_END]);
  assert_tx_done_clears_in_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pe_tx_done |=> !in_rdy);
  assert_rx_done_sets_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_rx_done && !pe_setup && !bus_reset) |=> out_rdy);
  assert_stall_sent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_stall_sent && !bus_reset) |=> csr_q[B_SENT_STALL]);
  assert_setup_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_setup || bus_reset) |=> !dir_in);
endmodule

// File: rtl/ep1_toggle.sv
module ep1_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic ack,
  output logic toggle_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     toggle_q <= 1'b0;
    else if (clear) toggle_q <= 1'b0;
    else if (ack)   toggle_q <= ~toggle_q;
  end

  assert_toggle_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> !toggle_q);
  assert_toggle_flip_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !clear) |=> (toggle_q != $past(toggle_q)));
endmodule

// File: rtl/usb_ep0_regs.sv
module usb_ep0_regs
  import usb_ep0_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [SEL_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [6:0]        func_addr,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [DATA_W-1:0] rx_data,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [DATA_W-1:0] tx_data,
  input  logic              pe_setup,
  input  logic              pe_rx_done,
  input  logic              pe_tx_done,
  input  logic              pe_stall_sent,
  input  logic              pe_bus_reset,
  input  logic              ep1_ack,
  output logic              stall_req,
  output logic              ep0_dir_in,
  output logic              ep1_toggle
);
  reg_sel_e          sel;
  logic              wr_faddr, wr_ep0, wr_ep1, wr_fifo, rd_fifo;
  logic [6:0]        faddr_q;
  logic [DATA_W-1:0] bcnt_q, csr_q, fifo_rdata, fifo_wdata;
  logic [CW-1:0]     fifo_cnt;
  logic              fifo_full, fifo_empty, fifo_push, fifo_pop, fifo_flush;
  logic              csr_flush, out_rdy, in_rdy, dir_in, rx_fire;

  assign sel      = reg_sel_e'(reg_addr);
  assign wr_faddr = reg_wr && (sel == SEL_FADDR);
  assign wr_ep0   = reg_wr && (sel == SEL_EP0);
  assign wr_ep1   = reg_wr && (sel == SEL_EP1);
  assign wr_fifo  = reg_wr && (sel == SEL_FIFO);
  assign rd_fifo  = reg_rd && (sel == SEL_FIFO);

  // device address
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            faddr_q <= '0;
    else if (pe_bus_reset) faddr_q <= '0;
    else if (wr_faddr)     faddr_q <= reg_wdata[6:0];
  end
  assign func_addr = faddr_q;

  // received byte count
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        bcnt_q <= '0;
    else if (pe_bus_reset)             bcnt_q <= '0;
    else if (pe_rx_done && !pe_setup)  bcnt_q <= {{(DATA_W-CW){1'b0}}, fifo_cnt};
  end

  // stream sides
  assign rx_ready   = !dir_in && !out_rdy && !fifo_full;
  assign rx_fire    = rx_valid && rx_ready;
  assign tx_valid   = dir_in && in_rdy && !fifo_empty;
  assign tx_data    = fifo_rdata;
  assign fifo_push  = dir_in ? (wr_fifo && !in_rdy) : rx_fire;
  assign fifo_wdata = dir_in ? reg_wdata : rx_data;
  assign fifo_pop   = dir_in ? (tx_valid && tx_ready) : rd_fifo;
  assign fifo_flush = pe_bus_reset || csr_flush;

  ep0_csr u_csr (
    .clk               (clk),
    .rst_n             (rst_n),
    .bus_reset         (pe_bus_reset),
    .csr_wr            (wr_ep0),
    .cmd_clr_setup_end (wr_ep0 && reg_wdata[B_CLR_SETUP_END]),
    .cmd_clr_out       (wr_ep0 && reg_wdata[B_CLR_OUT]),
    .cmd_set_data_end  (wr_ep0 && reg_wdata[B_DATA_END]),
    .cmd_set_in        (wr_ep0 && reg_wdata[B_IN_RDY]),
    .wr_stall_val      (reg_wdata[B_SEND_STALL]),
    .pe_setup          (pe_setup),
    .pe_rx_done        (pe_rx_done),
    .pe_tx_done        (pe_tx_done),
    .pe_stall_sent     (pe_stall_sent),
    .rx_push           (rx_fire),
    .rx_bit7           (rx_data[DATA_W-1]),
    .csr_q             (csr_q),
    .out_rdy           (out_rdy),
    .in_rdy            (in_rdy),
    .send_stall        (stall_req),
    .dir_in            (dir_in),
    .fifo_flush        (csr_flush)
  );
  assign ep0_dir_in = dir_in;

  ep0_fifo #(.DEPTH(FIFO_DEPTH), .W(DATA_W)) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (fifo_flush),
    .push  (fifo_push),
    .wdata (fifo_wdata),
    .pop   (fifo_pop),
    .rdata (fifo_rdata),
    .count (fifo_cnt),
    .full  (fifo_full),
    .empty (fifo_empty)
  );

  ep1_toggle u_tog (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (pe_bus_reset || (wr_ep1 && reg_wdata[B_EP1_CLR_TOG])),
    .ack      (ep1_ack),
    .toggle_q (ep1_toggle)
  );

  always_comb begin
    case (sel)
      SEL_FADDR: reg_rdata = {1'b0, faddr_q};
      SEL_EP0:   reg_rdata = csr_q;
      SEL_EP1:   reg_rdata = {{(DATA_W-1){1'b0}}, ep1_toggle};
      SEL_BCNT:  reg_rdata = bcnt_q;
      SEL_FIFO:  reg_rdata = dir_in ? '0 : fifo_rdata;
      default:   reg_rdata = '0;
    endcase
  end

  assert_bus_reset_addr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    pe_bus_reset |=> (func_addr == '0));
  assert_addr_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_faddr && !pe_bus_reset) |=> (func_addr == $past(reg_wdata[6:0])));
  assert_bcnt_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!pe_rx_done && !pe_bus_reset) |=> $stable(bcnt_q));
endmodule

// File: tb/sim_usb_ep0_regs.sv
module sim_usb_ep0_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 0, reg_rd = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [6:0] func_addr;
  logic       rx_valid = 0, rx_ready, tx_valid, tx_ready = 0;
  logic [7:0] rx_data = 0, tx_data;
  logic       pe_setup = 0, pe_rx_done = 0, pe_tx_done = 0, pe_stall_sent = 0;
  logic       pe_bus_reset = 0, ep1_ack = 0;
  logic       stall_req, ep0_dir_in, ep1_toggle;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  usb_ep0_regs u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .func_addr(func_addr), .rx_valid(rx_valid), .rx_ready(rx_ready),
    .rx_data(rx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .tx_data(tx_data), .pe_setup(pe_setup), .pe_rx_done(pe_rx_done),
    .pe_tx_done(pe_tx_done), .pe_stall_sent(pe_stall_sent),
    .pe_bus_reset(pe_bus_reset), .ep1_ack(ep1_ack), .stall_req(stall_req),
    .ep0_dir_in(ep0_dir_in), .ep1_toggle(ep1_toggle)
  );

  // {write value, expected read-back} for the address register
  localparam logic [15:0] ADDR_VEC [8] = '{
    16'h0000, 16'h7F7F, 16'hFF7F, 16'h8000,
    16'h5555, 16'hAA2A, 16'h0101, 16'hC343
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_rd = 1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] exp, input string tag);
    logic [7:0] v;
    rd(a, v);
    chk(v, exp, tag);
  endtask

  task automatic rx_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1; rx_data = b;
    @(negedge clk);
    rx_valid = 0;
  endtask

  task automatic strobe(input int which);
    @(negedge clk);
    case (which)
      0: pe_setup = 1;
      1: pe_rx_done = 1;
      2: pe_tx_done = 1;
      3: pe_stall_sent = 1;
      4: pe_bus_reset = 1;
      default: ep1_ack = 1;
    endcase
    @(negedge clk);
    pe_setup = 0; pe_rx_done = 0; pe_tx_done = 0;
    pe_stall_sent = 0; pe_bus_reset = 0; ep1_ack = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=finish");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] got [12];
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R2 reset state
    rd_chk(3'd0, 8'h00, "R2 addr");
    rd_chk(3'd1, 8'h00, "R2 ep0 status");
    rd_chk(3'd2, 8'h00, "R2 ep1 status");
    rd_chk(3'd3, 8'h00, "R2 count");
    chk({7'd0, ep0_dir_in}, 8'h00, "R2 direction");
    chk({7'd0, rx_ready}, 8'h01, "R2 rx_ready");
    chk({7'd0, tx_valid}, 8'h00, "R2 tx_valid");

    // R1 address register vectors
    for (int i = 0; i < 8; i++) begin
      wr(3'd0, ADDR_VEC[i][15:8]);
      rd_chk(3'd0, ADDR_VEC[i][7:0], "R1 readback");
      chk({1'b0, func_addr}, ADDR_VEC[i][7:0], "R1 func_addr");
    end

    // setup packet, device-to-host request
    strobe(0);
    rx_byte(8'h80); rx_byte(8'h06); rx_byte(8'h00); rx_byte(8'h01);
    rx_byte(8'h00); rx_byte(8'h00); rx_byte(8'h40); rx_byte(8'h00);
    chk({7'd0, rx_ready}, 8'h00, "R3 full blocks rx");
    strobe(1);
    rd_chk(3'd1, 8'h01, "R3 out ready set");
    rd_chk(3'd3, 8'h08, "R3 byte count");
    rd_chk(3'd4, 8'h80, "R4 byte0");
    rd_chk(3'd4, 8'h06, "R4 byte1");
    rd_chk(3'd4, 8'h00, "R4 byte2");
    rd_chk(3'd3, 8'h08, "R12 count unchanged by reads");
    wr(3'd1, 8'h40);
    rd_chk(3'd1, 8'h00, "R5 out ready cleared");
    chk({7'd0, ep0_dir_in}, 8'h01, "R5 direction from setup");
    rd_chk(3'd4, 8'h00, "R4 read while device-to-host");

    // IN data stage, ten writes into eight slots
    for (int i = 0; i < 10; i++) wr(3'd4, 8'h10 + 8'(i));
    wr(3'd1, 8'h0A);
    rd_chk(3'd1, 8'h0A, "R8 data end and in ready set");
    @(negedge clk);
    tx_ready = 1;
    n = 0;
    for (int i = 0; i < 12; i++) begin
      if (tx_valid && n < 12) begin got[n] = tx_data; n++; end
      @(negedge clk);
    end
    tx_ready = 0;
    chk(8'(n), 8'h08, "R7 tx byte total");
    for (int i = 0; i < 8; i++) chk(got[i], 8'h10 + 8'(i), "R7 tx order");
    strobe(2);
    rd_chk(3'd1, 8'h00, "R7 R8 tx done clears flags");

    // setup, then a second setup while transfer open
    strobe(0);
    chk({7'd0, ep0_dir_in}, 8'h00, "R5 setup restores direction");
    for (int i = 0; i < 8; i++) rx_byte(i == 1 ? 8'h09 : 8'h00);
    strobe(1);
    rd_chk(3'd1, 8'h01, "R3 second setup received");
    strobe(0);
    rd_chk(3'd1, 8'h10, "R6 setup end raised");
    rx_byte(8'h00); rx_byte(8'h05); rx_byte(8'h22); rx_byte(8'h00);
    rx_byte(8'h00); rx_byte(8'h00); rx_byte(8'h00); rx_byte(8'h00);
    strobe(1);
    rd_chk(3'd1, 8'h11, "R6 setup end with out ready");
    wr(3'd1, 8'h80);
    rd_chk(3'd1, 8'h01, "R6 setup end cleared");
    rd_chk(3'd4, 8'h00, "R4 s0");
    rd_chk(3'd4, 8'h05, "R4 s1");
    rd_chk(3'd4, 8'h22, "R4 s2");
    for (int i = 0; i < 5; i++) rd_chk(3'd4, 8'h00, "R4 s-rest");
    rd_chk(3'd4, 8'h00, "R4 empty read");
    rd_chk(3'd3, 8'h08, "R12 count held");
    wr(3'd1, 8'h40);
    rd_chk(3'd1, 8'h00, "R5 cleared");
    chk({7'd0, ep0_dir_in}, 8'h00, "R5 host-to-device kept");

    // status OUT with data end
    wr(3'd1, 8'h08);
    rd_chk(3'd1, 8'h08, "R8 data end set");
    rx_byte(8'hA1); rx_byte(8'hA2); rx_byte(8'hA3);
    strobe(1);
    rd_chk(3'd1, 8'h01, "R8 data end cleared by rx");
    rd_chk(3'd3, 8'h03, "R12 count reloaded");
    strobe(0);
    rd_chk(3'd1, 8'h00, "R8 transfer closed, no setup end");

    // stall
    wr(3'd1, 8'h20);
    chk({7'd0, stall_req}, 8'h01, "R9 stall_req");
    strobe(3);
    rd_chk(3'd1, 8'h24, "R9 sent stall");
    wr(3'd1, 8'h00);
    rd_chk(3'd1, 8'h00, "R9 sent stall cleared");
    chk({7'd0, stall_req}, 8'h00, "R9 stall_req off");

    // interrupt endpoint toggle
    strobe(5);
    rd_chk(3'd2, 8'h01, "R11 toggle flip");
    strobe(5);
    rd_chk(3'd2, 8'h00, "R11 toggle flip back");
    strobe(5);
    chk({7'd0, ep1_toggle}, 8'h01, "R11 toggle port");
    wr(3'd2, 8'h80);
    rd_chk(3'd2, 8'h00, "R11 toggle cleared");

    // bus reset
    wr(3'd0, 8'h33);
    strobe(0);
    rx_byte(8'h80);
    for (int i = 0; i < 7; i++) rx_byte(8'h00);
    strobe(1);
    wr(3'd1, 8'h40);
    wr(3'd4, 8'h55);
    wr(3'd1, 8'h20);
    strobe(5);
    chk({7'd0, ep0_dir_in}, 8'h01, "R5 pre-reset direction");
    strobe(4);
    rd_chk(3'd0, 8'h00, "R10 addr");
    rd_chk(3'd1, 8'h00, "R10 status");
    rd_chk(3'd3, 8'h00, "R10 count");
    rd_chk(3'd2, 8'h00, "R10 toggle");
    chk({7'd0, ep0_dir_in}, 8'h00, "R10 direction");
    chk({7'd0, rx_ready}, 8'h01, "R10 rx_ready");
    chk({7'd0, tx_valid}, 8'h00, "R10 tx_valid");
    chk({7'd0, stall_req}, 8'h00, "R10 stall_req");
    rd_chk(3'd4, 8'h00, "R10 fifo empty");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule